// File: doc/BRIEF.md
# Load-Store Request Tracker with Fence

This block sits between an instruction issue queue and a multi-lane memory port. It accepts three kinds of operation: load, store and fence. For each load or store it builds a memory request. The request's lane mask is taken from the issuing thread mask for the selected lane group, and inactive lanes have their addresses cleared. A load is recorded in a pending-read table and sends the index of its table entry as the request tag. The load completes only once memory responses, which may arrive in several partial pieces, have returned every active lane. A store needs no table entry, goes out with tag zero, and completes on the next cycle.

A fence is consumed at once and locks the issue path. While the lock is set no operation is accepted. The fence completes, and the lock clears, one cycle after a cycle that begins with the pending-read table empty. Completions from load responses, stores and fences share a single output that carries the warp id. Two counters are kept: one for outstanding load lanes, and one that adds that figure to a running latency total every cycle.

Top module: `lsu_tracker`

## Requirements
- R1: After synchronous reset the request, completion and error outputs are low, the empty flag is high, the full flag is low, both counters read zero, and the block is ready to accept an operation.
- R2: A request appears on the cycle after its operation is accepted. Its lane mask equals thread-mask bits [grp*LANES +: LANES]. Each inactive lane's address field reads zero, and each active lane carries the issued address.
- R3: An accepted load (op code 0) sends a request with the write flag low. Its tag is the lowest-numbered table entry that is free in that cycle.
- R4: A response whose lane mask lies within a tag's remaining mask clears those bits. The response that clears the last bit frees the tag and produces a completion with the load's warp id on the next cycle.
- R5: When no table entry is free, a load is not accepted (ready low) and stays at the input. A store (op code 1) is still accepted while the table is full.
- R6: An accepted store sends a request with the write flag high and tag 0. It produces a completion with its warp id on the next cycle.
- R7: A fence (op code 2) is accepted without sending a request. From the next cycle, ready stays low for every op until the fence completes. The fence completes, with its warp id, on the cycle after a cycle that began with the table empty, and acceptance resumes on that same cycle.
- R8: A tag freed by a response is available to a load accepted in the same cycle, and this applies even when the table was full.
- R9: The outstanding-lane count rises by the number of active lanes of each accepted load and falls by the number of lanes in each accepted response. The latency total grows every cycle by the count held at the start of that cycle.
- R10: A response to a free tag, or one with a lane bit not outstanding for that tag, raises the error output for one cycle and leaves the table and counters unchanged.
- R11: In a cycle where a response completes a load, a store is not accepted (ready low), so that the response takes the completion output.
- R12: The full and empty flags are registered and describe the table as it stands after each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Operation offered |
| iss_ready | output | 1 | Operation accepted this cycle when valid |
| iss_op | input | 2 | 0 load, 1 store, 2 fence (3 unused) |
| iss_wid | input | WID_W | Warp id of the operation |
| iss_tmask | input | LANES*GROUPS | Thread mask across all lane groups |
| iss_grp | input | GRP_W | Lane group selecting the mask slice |
| iss_addr | input | LANES*ADDR_W | Per-lane addresses |
| mreq_valid | output | 1 | Memory request valid |
| mreq_write | output | 1 | High for a store |
| mreq_tag | output | TAG_W | Table entry of a load, zero for a store |
| mreq_mask | output | LANES | Active lanes |
| mreq_addr | output | LANES*ADDR_W | Addresses, zero on inactive lanes |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_tag | input | TAG_W | Tag of the response |
| mrsp_mask | input | LANES | Lanes returned by the response |
| cpl_valid | output | 1 | Completion valid |
| cpl_wid | output | WID_W | Warp id of the completed operation |
| rsp_err | output | 1 | Pulse on an illegal response |
| tbl_full | output | 1 | No free table entry |
| tbl_empty | output | 1 | No table entry in use |
| pend_lanes | output | PEND_W | Outstanding load lanes |
| lat_acc | output | LAT_W | Accumulated outstanding-lane cycles |

## Verification
The hardest situation to reach from the ports is a single cycle that does three things at once: it completes a load through a response, it frees that load's tag while the table is full, and it offers a new load or a store. This is the cycle that decides whether tags are reused in the same cycle and whether stores yield to responses. The stimulus builds it directly. It issues loads until the table is full, then pairs a full-mask response with a load in the same cycle, and then pairs another full-mask response with a store. A behavioural model then drives a long random phase in which the responder returns random subsets of each tag's remaining lanes, so fences regularly wait on loads that are only partly answered.

// File: rtl/lsu_trk_pkg.sv
// Package: shared operation codes for the load-store request tracker.
// Assumes a 2-bit op field on the issue interface; code 3 is not used.
package lsu_trk_pkg;
    typedef enum logic [1:0] {
        LSU_OP_LOAD  = 2'd0,
        LSU_OP_STORE = 2'd1,
        LSU_OP_FENCE = 2'd2
    } lsu_op_e;
endpackage

// File: rtl/lsu_trk_lanes.sv
// Module: lsu_trk_lanes
// Picks the lane-group slice of the thread mask and zeroes the address of
// every inactive lane. Purely combinational; assumes grp < GROUPS.
module lsu_trk_lanes #(
    parameter int LANES  = 4,
    parameter int GROUPS = 2,
    parameter int ADDR_W = 16,
    localparam int THREADS = LANES * GROUPS,
    localparam int GRP_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic [THREADS-1:0]      tmask,
    input  logic [GRP_W-1:0]        grp,
    input  logic [LANES*ADDR_W-1:0] addr_in,
    output logic [LANES-1:0]        lanes,
    output logic [LANES*ADDR_W-1:0] addr_out
);
    // Slice of the thread mask for the selected group
    assign lanes = tmask[int'(grp)*LANES +: LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Address passes only for an active lane
        assign addr_out[l*ADDR_W +: ADDR_W] =
            lanes[l] ? addr_in[l*ADDR_W +: ADDR_W] : '0;
    end
endmodule

// File: rtl/lsu_trk_table.sv
// Module: lsu_trk_table
// Pending-read table. Each entry holds the owner warp id and the lanes still
// outstanding. A response is applied before allocation in the same cycle, so
// a tag freed by a response can be reused at once. The allocator picks the
// lowest free index. Full and empty flags are registered.
module lsu_trk_table #(
    parameter int LANES = 4,
    parameter int TAG_W = 2,
    parameter int WID_W = 3,
    localparam int TAGS = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_tag,
    input  logic [LANES-1:0] rsp_mask,
    input  logic             alloc_en,
    input  logic [LANES-1:0] alloc_mask,
    input  logic [WID_W-1:0] alloc_wid,
    output logic             rsp_ok,
    output logic             rsp_bad,
    output logic             rsp_retire,
    output logic [WID_W-1:0] rsp_wid,
    output logic             free_any,
    output logic [TAG_W-1:0] alloc_tag,
    output logic             full_q,
    output logic             empty_q
);
    logic [TAGS-1:0]  valid_q;
    logic [LANES-1:0] rem_q [TAGS];
    logic [WID_W-1:0] wid_q [TAGS];
    logic [TAGS-1:0]  valid_rel;
    logic [TAGS-1:0]  valid_next;
    logic [LANES-1:0] sel_rem;

    // Classify the incoming response against the addressed entry
    always_comb begin
        sel_rem    = rem_q[rsp_tag];
        rsp_bad    = rsp_valid && (!valid_q[rsp_tag] || ((rsp_mask & ~sel_rem) != '0));
        rsp_ok     = rsp_valid && !rsp_bad;
        rsp_retire = rsp_ok && ((sel_rem & ~rsp_mask) == '0);
        rsp_wid    = wid_q[rsp_tag];
    end

    // Release the retiring tag, then find the lowest free entry
    always_comb begin
        valid_rel = valid_q;
        if (rsp_retire) valid_rel[rsp_tag] = 1'b0;
        alloc_tag = '0;
        free_any  = 1'b0;
        for (int i = TAGS - 1; i >= 0; i--) begin
            if (!valid_rel[i]) begin
                alloc_tag = TAG_W'(i);
                free_any  = 1'b1;
            end
        end
        valid_next = valid_rel;
        if (alloc_en) valid_next[alloc_tag] = 1'b1;
    end

    // Occupancy bits and registered flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            valid_q <= valid_next;
            full_q  <= &valid_next;
            empty_q <= ~|valid_next;
        end
    end

    // Entry contents: allocation wins over a partial clear of the same index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAGS; i++) begin
                rem_q[i] <= '0;
                wid_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < TAGS; i++) begin
                if (alloc_en && alloc_tag == TAG_W'(i)) begin
                    rem_q[i] <= alloc_mask;
                    wid_q[i] <= alloc_wid;
                end else if (rsp_ok && rsp_tag == TAG_W'(i)) begin
                    rem_q[i] <= rem_q[i] & ~rsp_mask;
                end
            end
        end
    end
endmodule

// File: rtl/lsu_trk_retire.sv
// Module: lsu_trk_retire
// Merges the three completion sources onto one registered output.
// Response-side completions win, then stores, then fences. The top module
// guarantees that at most one source is active in a cycle.
module lsu_trk_retire #(
    parameter int WID_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_done,
    input  logic [WID_W-1:0] ld_wid,
    input  logic             st_done,
    input  logic [WID_W-1:0] st_wid,
    input  logic             fn_done,
    input  logic [WID_W-1:0] fn_wid,
    output logic             cpl_valid,
    output logic [WID_W-1:0] cpl_wid
);
    // Register the highest-priority completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_valid <= 1'b0;
            cpl_wid   <= '0;
        end else begin
            cpl_valid <= ld_done || st_done || fn_done;
            if (ld_done)      cpl_wid <= ld_wid;
            else if (st_done) cpl_wid <= st_wid;
            else if (fn_done) cpl_wid <= fn_wid;
        end
    end
endmodule

// File: rtl/lsu_tracker.sv
// Module: lsu_tracker (top)
// Accepts loads, stores and fences. It builds one lane-masked memory request
// per load or store, tracks loads in a tag table until all lanes return, and
// holds issue behind a fence until the table drains. Assumes every load has
// at least one active lane in its group and that op code 3 is never offered.
module lsu_tracker
    import lsu_trk_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int GROUPS = 2,
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 2,
    parameter int WID_W  = 3,
    parameter int LAT_W  = 32,
    localparam int THREADS = LANES * GROUPS,
    localparam int GRP_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int TAGS    = 1 << TAG_W,
    localparam int PEND_W  = $clog2(TAGS * LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_valid,
    output logic                    iss_ready,
    input  logic [1:0]              iss_op,
    input  logic [WID_W-1:0]        iss_wid,
    input  logic [THREADS-1:0]      iss_tmask,
    input  logic [GRP_W-1:0]        iss_grp,
    input  logic [LANES*ADDR_W-1:0] iss_addr,
    output logic                    mreq_valid,
    output logic                    mreq_write,
    output logic [TAG_W-1:0]        mreq_tag,
    output logic [LANES-1:0]        mreq_mask,
    output logic [LANES*ADDR_W-1:0] mreq_addr,
    input  logic                    mrsp_valid,
    input  logic [TAG_W-1:0]        mrsp_tag,
    input  logic [LANES-1:0]        mrsp_mask,
    output logic                    cpl_valid,
    output logic [WID_W-1:0]        cpl_wid,
    output logic                    rsp_err,
    output logic                    tbl_full,
    output logic                    tbl_empty,
    output logic [PEND_W-1:0]       pend_lanes,
    output logic [LAT_W-1:0]        lat_acc
);
    lsu_op_e                 op;
    logic [LANES-1:0]        lanes;
    logic [LANES*ADDR_W-1:0] lane_addr;
    logic                    rsp_ok, rsp_bad, rsp_retire, free_any;
    logic [WID_W-1:0]        rsp_wid;
    logic [TAG_W-1:0]        alloc_tag;
    logic                    fire, ld_fire, st_fire, fn_fire, fn_done;
    logic                    lock_q;
    logic [WID_W-1:0]        fence_wid_q;

    assign op = lsu_op_e'(iss_op);

    lsu_trk_lanes #(.LANES(LANES), .GROUPS(GROUPS), .ADDR_W(ADDR_W)) u_lanes (
        .tmask    (iss_tmask),
        .grp      (iss_grp),
        .addr_in  (iss_addr),
        .lanes    (lanes),
        .addr_out (lane_addr)
    );

    lsu_trk_table #(.LANES(LANES), .TAG_W(TAG_W), .WID_W(WID_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsp_valid  (mrsp_valid),
        .rsp_tag    (mrsp_tag),
        .rsp_mask   (mrsp_mask),
        .alloc_en   (ld_fire),
        .alloc_mask (lanes),
        .alloc_wid  (iss_wid),
        .rsp_ok     (rsp_ok),
        .rsp_bad    (rsp_bad),
        .rsp_retire (rsp_retire),
        .rsp_wid    (rsp_wid),
        .free_any   (free_any),
        .alloc_tag  (alloc_tag),
        .full_q     (tbl_full),
        .empty_q    (tbl_empty)
    );

    // Acceptance rule per op; a store yields to a retiring response
    always_comb begin
        unique case (op)
            LSU_OP_LOAD:  iss_ready = !lock_q && free_any;
            LSU_OP_STORE: iss_ready = !lock_q && !rsp_retire;
            LSU_OP_FENCE: iss_ready = !lock_q;
            default:      iss_ready = 1'b0;
        endcase
    end

    assign fire    = iss_valid && iss_ready;
    assign ld_fire = fire && (op == LSU_OP_LOAD);
    assign st_fire = fire && (op == LSU_OP_STORE);
    assign fn_fire = fire && (op == LSU_OP_FENCE);
    assign fn_done = lock_q && tbl_empty;

    // Fence lock: set on accept, cleared when the drained fence retires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q      <= 1'b0;
            fence_wid_q <= '0;
        end else if (fn_done) begin
            lock_q <= 1'b0;
        end else if (fn_fire) begin
            lock_q      <= 1'b1;
            fence_wid_q <= iss_wid;
        end
    end

    // Memory request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mreq_valid <= 1'b0;
            mreq_write <= 1'b0;
            mreq_tag   <= '0;
            mreq_mask  <= '0;
            mreq_addr  <= '0;
        end else begin
            mreq_valid <= ld_fire || st_fire;
            if (ld_fire || st_fire) begin
                mreq_write <= st_fire;
                mreq_tag   <= ld_fire ? alloc_tag : '0;
                mreq_mask  <= lanes;
                mreq_addr  <= lane_addr;
            end
        end
    end

    // Outstanding-lane count, latency total and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_lanes <= '0;
            lat_acc    <= '0;
            rsp_err    <= 1'b0;
        end else begin
            pend_lanes <= pend_lanes
                        + (ld_fire ? PEND_W'($countones(lanes)) : '0)
                        - (rsp_ok ? PEND_W'($countones(mrsp_mask)) : '0);
            lat_acc    <= lat_acc + LAT_W'(pend_lanes);
            rsp_err    <= rsp_bad;
        end
    end

    lsu_trk_retire #(.WID_W(WID_W)) u_retire (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_done   (rsp_retire),
        .ld_wid    (rsp_wid),
        .st_done   (st_fire),
        .st_wid    (iss_wid),
        .fn_done   (fn_done),
        .fn_wid    (fence_wid_q),
        .cpl_valid (cpl_valid),
        .cpl_wid   (cpl_wid)
    );
endmodule

// File: rtl/lsu_tracker_checker.sv
// Module: lsu_tracker_checker
// Port-level properties of the tracker, attached to every instance by bind.
module lsu_tracker_checker #(
    parameter int LANES  = 4,
    parameter int TAG_W  = 2,
    parameter int WID_W  = 3,
    parameter int PEND_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [1:0]        iss_op,
    input logic [WID_W-1:0]  iss_wid,
    input logic              mreq_valid,
    input logic              mreq_write,
    input logic [TAG_W-1:0]  mreq_tag,
    input logic              mrsp_valid,
    input logic              cpl_valid,
    input logic [WID_W-1:0]  cpl_wid,
    input logic              tbl_full,
    input logic              tbl_empty,
    input logic [PEND_W-1:0] pend_lanes
);
    assert_store_tag_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid && mreq_write |-> mreq_tag == '0);

    assert_store_cpl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready && iss_op == 2'd1 |=> cpl_valid && cpl_wid == $past(iss_wid));

    assert_fence_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready && iss_op == 2'd2 |=> !iss_ready);

    assert_full_blocks_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        iss_op == 2'd0 && tbl_full && !mrsp_valid |-> !iss_ready);

    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(tbl_full && tbl_empty));

    assert_empty_no_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_empty |-> pend_lanes == '0);
endmodule

bind lsu_tracker lsu_tracker_checker #(
    .LANES(LANES), .TAG_W(TAG_W), .WID_W(WID_W), .PEND_W(PEND_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_op     (iss_op),
    .iss_wid    (iss_wid),
    .mreq_valid (mreq_valid),
    .mreq_write (mreq_write),
    .mreq_tag   (mreq_tag),
    .mrsp_valid (mrsp_valid),
    .cpl_valid  (cpl_valid),
    .cpl_wid    (cpl_wid),
    .tbl_full   (tbl_full),
    .tbl_empty  (tbl_empty),
    .pend_lanes (pend_lanes)
);

// File: tb/lsu_tracker_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped once per clock and compared
// with every output of lsu_tracker.
module lsu_tracker_bench;
    localparam int LANES = 4, GROUPS = 2, ADDR_W = 16, TAG_W = 2, WID_W = 3, LAT_W = 32;
    localparam int THREADS = LANES * GROUPS;
    localparam int GRP_W = 1;
    localparam int TAGS = 1 << TAG_W;
    localparam int PEND_W = $clog2(TAGS * LANES + 1);
    localparam logic [1:0] LD = 2'd0, ST = 2'd1, FN = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0, iss_ready;
    logic [1:0] iss_op = LD;
    logic [WID_W-1:0] iss_wid = '0;
    logic [THREADS-1:0] iss_tmask = '0;
    logic [GRP_W-1:0] iss_grp = '0;
    logic [LANES*ADDR_W-1:0] iss_addr = '0;
    logic mreq_valid, mreq_write;
    logic [TAG_W-1:0] mreq_tag;
    logic [LANES-1:0] mreq_mask;
    logic [LANES*ADDR_W-1:0] mreq_addr;
    logic mrsp_valid = 1'b0;
    logic [TAG_W-1:0] mrsp_tag = '0;
    logic [LANES-1:0] mrsp_mask = '0;
    logic cpl_valid, rsp_err, tbl_full, tbl_empty;
    logic [WID_W-1:0] cpl_wid;
    logic [PEND_W-1:0] pend_lanes;
    logic [LAT_W-1:0] lat_acc;

    always #2 clk = ~clk;

    lsu_tracker #(.LANES(LANES), .GROUPS(GROUPS), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
                  .WID_W(WID_W), .LAT_W(LAT_W)) u_lsu_tracker (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_op(iss_op), .iss_wid(iss_wid), .iss_tmask(iss_tmask), .iss_grp(iss_grp),
        .iss_addr(iss_addr), .mreq_valid(mreq_valid), .mreq_write(mreq_write),
        .mreq_tag(mreq_tag), .mreq_mask(mreq_mask), .mreq_addr(mreq_addr),
        .mrsp_valid(mrsp_valid), .mrsp_tag(mrsp_tag), .mrsp_mask(mrsp_mask),
        .cpl_valid(cpl_valid), .cpl_wid(cpl_wid), .rsp_err(rsp_err),
        .tbl_full(tbl_full), .tbl_empty(tbl_empty), .pend_lanes(pend_lanes),
        .lat_acc(lat_acc)
    );

    int nchecks = 0, nfail = 0;
    bit done = 0;

    // Reference model state
    bit m_val [TAGS];
    logic [LANES-1:0] m_rem [TAGS];
    logic [WID_W-1:0] m_wid [TAGS];
    bit m_lock = 0;
    logic [WID_W-1:0] m_fwid = '0;
    int m_pend = 0;
    logic [LAT_W-1:0] m_lat = '0;

    task automatic chk(input bit ok, input string what, input longint act, input longint expv);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    // One clock: drive at negedge, predict, compare after the next edge
    task automatic step(input bit v, input logic [1:0] op, input logic [WID_W-1:0] wid,
                        input logic [THREADS-1:0] tm, input logic [GRP_W-1:0] grp,
                        input logic [LANES*ADDR_W-1:0] ad, input bit rv,
                        input logic [TAG_W-1:0] rt, input logic [LANES-1:0] rm);
        logic [LANES-1:0] lanes;
        logic [LANES*ADDR_W-1:0] madr;
        bit err, ok, ret, exp_rdy, fire, fret, empty0, anyfree;
        bit v2 [TAGS];
        int ftag, pend_old;
        bit e_mv, e_mw, e_cv, e_err, e_full, e_empty;
        logic [TAG_W-1:0] e_tag;
        logic [WID_W-1:0] e_cw;
        iss_valid = v; iss_op = op; iss_wid = wid; iss_tmask = tm; iss_grp = grp;
        iss_addr = ad; mrsp_valid = rv; mrsp_tag = rt; mrsp_mask = rm;
        #1;
        lanes = tm[grp*LANES +: LANES];
        for (int l = 0; l < LANES; l++)
            madr[l*ADDR_W +: ADDR_W] = lanes[l] ? ad[l*ADDR_W +: ADDR_W] : '0;
        err = rv && (!m_val[rt] || ((rm & ~m_rem[rt]) != '0));
        ok  = rv && !err;
        ret = ok && ((m_rem[rt] & ~rm) == '0);
        empty0 = 1;
        for (int i = 0; i < TAGS; i++) begin
            v2[i] = m_val[i];
            if (m_val[i]) empty0 = 0;
        end
        if (ret) v2[rt] = 0;
        ftag = -1;
        for (int i = 0; i < TAGS; i++) if (!v2[i] && ftag < 0) ftag = i;
        anyfree = (ftag >= 0);
        exp_rdy = !m_lock && (op == FN || (op == ST && !ret) || (op == LD && anyfree));
        chk(iss_ready === exp_rdy, "R5 R7 R8 R11 iss_ready", iss_ready, exp_rdy);
        fire = v && exp_rdy;
        fret = m_lock && empty0;
        e_mv = fire && op != FN;
        e_mw = (op == ST);
        e_tag = (op == LD && ftag >= 0) ? TAG_W'(ftag) : '0;
        e_err = err;
        e_cv = ret || (fire && op == ST) || fret;
        e_cw = ret ? m_wid[rt] : (fire && op == ST) ? wid : m_fwid;
        pend_old = m_pend;
        if (ok) begin
            m_rem[rt] = m_rem[rt] & ~rm;
            m_pend -= $countones(rm);
        end
        if (ret) m_val[rt] = 0;
        if (fire && op == LD) begin
            m_val[ftag] = 1; m_rem[ftag] = lanes; m_wid[ftag] = wid;
            m_pend += $countones(lanes);
        end
        if (fret) m_lock = 0;
        if (fire && op == FN) begin m_lock = 1; m_fwid = wid; end
        m_lat = m_lat + LAT_W'(pend_old);
        e_full = 1; e_empty = 1;
        for (int i = 0; i < TAGS; i++) begin
            if (m_val[i]) e_empty = 0; else e_full = 0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(mreq_valid === e_mv, "R2 R3 R6 mreq_valid", mreq_valid, e_mv);
        if (e_mv) begin
            chk(mreq_write === e_mw, "R3 R6 mreq_write", mreq_write, e_mw);
            chk(mreq_tag === e_tag, "R3 R6 R8 mreq_tag", mreq_tag, e_tag);
            chk(mreq_mask === lanes, "R2 mreq_mask", mreq_mask, lanes);
            chk(mreq_addr === madr, "R2 mreq_addr", mreq_addr, madr);
        end
        chk(cpl_valid === e_cv, "R4 R6 R7 cpl_valid", cpl_valid, e_cv);
        if (e_cv) chk(cpl_wid === e_cw, "R4 R6 R7 cpl_wid", cpl_wid, e_cw);
        chk(rsp_err === e_err, "R10 rsp_err", rsp_err, e_err);
        chk(tbl_full === e_full, "R12 tbl_full", tbl_full, e_full);
        chk(tbl_empty === e_empty, "R12 tbl_empty", tbl_empty, e_empty);
        chk(pend_lanes === PEND_W'(m_pend), "R9 pend_lanes", pend_lanes, m_pend);
        chk(lat_acc === m_lat, "R9 lat_acc", lat_acc, m_lat);
    endtask

    task automatic idle(input bit rv, input logic [TAG_W-1:0] rt, input logic [LANES-1:0] rm);
        step(0, LD, '0, '0, '0, '0, rv, rt, rm);
    endtask

    initial begin
        for (int i = 0; i < TAGS; i++) begin m_val[i] = 0; m_rem[i] = '0; m_wid[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(mreq_valid === 1'b0, "R1 mreq_valid", mreq_valid, 0);
        chk(cpl_valid === 1'b0, "R1 cpl_valid", cpl_valid, 0);
        chk(rsp_err === 1'b0, "R1 rsp_err", rsp_err, 0);
        chk(tbl_empty === 1'b1 && tbl_full === 1'b0, "R1 flags", {tbl_full, tbl_empty}, 1);
        chk(pend_lanes === '0 && lat_acc === '0, "R1 counters", pend_lanes, 0);
        chk(iss_ready === 1'b1, "R1 iss_ready", iss_ready, 1);
        rst_n = 1'b1;

        // R2 R3 R4: upper lane group, partial responses
        step(1, LD, 3'd1, 8'hA0, 1'b1, 64'h1111_2222_3333_4444, 0, '0, '0);
        idle(1, 2'd0, 4'b0010);
        idle(1, 2'd0, 4'b1000);
        idle(0, '0, '0);

        // R5 R6: fill the table, blocked load, store while full
        for (int k = 0; k < TAGS; k++)
            step(1, LD, WID_W'(k + 2), 8'h0F, 1'b0, 64'hA0A1_B0B1_C0C1_D0D1, 0, '0, '0);
        step(1, LD, 3'd6, 8'h0F, 1'b0, '0, 0, '0, '0);
        step(1, ST, 3'd7, 8'hFF, 1'b1, 64'h5555_6666_7777_8888, 0, '0, '0);
        // R8: retire and reuse tag 2 in one cycle while full
        step(1, LD, 3'd6, 8'h0F, 1'b0, 64'h0102_0304_0506_0708, 1, 2'd2, 4'hF);
        // R11: store held off by a retiring response
        step(1, ST, 3'd3, 8'hFF, 1'b0, '0, 1, 2'd1, 4'hF);
        // R10: free tag, then lanes no longer outstanding
        idle(1, 2'd1, 4'b0001);
        idle(1, 2'd0, 4'b0011);
        idle(1, 2'd0, 4'b0011);

        // R7: fence waits for the table to drain
        step(1, FN, 3'd5, '0, '0, '0, 0, '0, '0);
        step(1, LD, 3'd2, 8'h0F, 1'b0, '0, 1, 2'd0, 4'hC);
        step(1, ST, 3'd2, 8'h0F, 1'b0, '0, 1, 2'd2, 4'hF);
        idle(1, 2'd3, 4'hF);
        repeat (3) idle(0, '0, '0);

        // Random phase with a partial-lane responder
        for (int c = 0; c < 4000; c++) begin
            bit v, rv;
            int r, s;
            logic [1:0] op;
            logic [THREADS-1:0] tm;
            logic [GRP_W-1:0] grp;
            logic [TAG_W-1:0] rt;
            logic [LANES-1:0] rm;
            v = ($urandom % 10) < 7;
            r = $urandom % 20;
            op = (r < 10) ? LD : (r < 17) ? ST : FN;
            tm = THREADS'($urandom);
            grp = GRP_W'($urandom % GROUPS);
            if (op == LD && tm[grp*LANES +: LANES] == '0) tm[grp*LANES] = 1'b1;
            rv = 0; rt = '0; rm = '0;
            if ($urandom % 100 < 5) begin
                rv = 1; rt = TAG_W'($urandom); rm = LANES'($urandom);
            end else if ($urandom % 10 < 6) begin
                s = $urandom % TAGS;
                for (int k = 0; k < TAGS; k++) begin
                    if (!rv && m_val[(s + k) % TAGS]) begin
                        rv = 1;
                        rt = TAG_W'((s + k) % TAGS);
                        rm = m_rem[rt] & LANES'($urandom);
                        if (rm == '0) rm = m_rem[rt];
                    end
                end
            end
            step(v, op, WID_W'($urandom), tm, grp, {$urandom, $urandom}, rv, rt, rm);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end
endmodule